// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block keeps track of loads that were hoisted above stores the compiler could not prove independent. When such a load executes, it records an entry holding the destination register number and the byte range it read. Every later store is snooped against all recorded ranges, and any entry whose range the store touches is dropped. When the program reaches the point where the original load would have run, it issues a check for the destination register. If the entry is still present, the speculation held and the check reports a hit. If the entry is gone, the check raises a recover request so that recovery code can redo the load.

The table is fully associative and is searched in two ways. A check or an allocation looks entries up by register tag. A store snoop compares the store's byte range with every entry's range. A missing entry never causes a refill. It only means recovery is needed. When the table is full, an allocation takes a victim in round-robin order. A flush input empties the whole table in one cycle.

Top module: `ldspec_table`

## Requirements
- R1: An allocation request installs a valid entry holding the register, address and size. A check for that register issued in a later cycle reports a hit.
- R2: A store snoop whose byte range overlaps an entry's byte range invalidates that entry, and a later check for its register raises recover. A size code k (0 to 3) means an access of 2^k bytes starting at the given address.
- R3: A store snoop whose byte range does not overlap an entry leaves it valid, including ranges that end exactly where the entry begins or begin exactly where it ends.
- R4: A check for a register that has no valid entry raises chk_recover and leaves chk_hit low.
- R5: Each check produces exactly one result on the clock cycle after the request: either chk_hit or chk_recover, never both. Neither output is high in a cycle whose previous cycle had no check.
- R6: An allocation for a register that already has a valid entry overwrites that entry, and the old address range no longer affects it.
- R7: When a store snoop and a check hit the same entry in the same cycle, the store applies first and the check raises recover.
- R8: A check with chk_clear set reports its hit and then invalidates the entry. A check without chk_clear leaves the entry valid.
- R9: flush invalidates every entry in one cycle, and a check issued in the same cycle as flush raises recover.
- R10: An allocation that matches no register takes the lowest-numbered free entry. When no entry is free, it replaces the entry at a round-robin pointer. The pointer starts at entry 0 and advances by one, with wraparound, only on each replacement.
- R11: An allocation lands after any same-cycle flush, store invalidation or clearing check, so the new entry is valid afterwards.
- R12: Reset empties the table and drives chk_hit and chk_recover low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| alloc_valid | input | 1 | Advanced load allocation request |
| alloc_reg | input | REG_W | Destination register tag |
| alloc_addr | input | ADDR_W | Load byte address |
| alloc_size | input | 2 | Load size code, 2^code bytes |
| snoop_valid | input | 1 | Store snoop request |
| snoop_addr | input | ADDR_W | Store byte address |
| snoop_size | input | 2 | Store size code, 2^code bytes |
| chk_valid | input | 1 | Check request |
| chk_reg | input | REG_W | Register to check |
| chk_clear | input | 1 | Invalidate the entry after a hit |
| chk_hit | output | 1 | Registered: speculation held |
| chk_recover | output | 1 | Registered: recovery needed |

## Verification
The bench builds the table with ENTRIES set to 8, while REG_W (7) and ADDR_W (32) keep their default values. With only eight entries, a full table and repeated round-robin replacement, including pointer wraparound, come up often under random traffic and not only in the directed sequence. Random register tags are drawn from 0 to 15 and addresses from 0 to 63. This makes register reuse, partial byte overlaps and same-cycle store/check collisions common.

// File: rtl/ldspec_pkg.sv
package ldspec_pkg;

  // access size code: 2^code bytes
  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } acc_size_e;

  localparam int SPAN_W = 4;

  function automatic logic [SPAN_W-1:0] span_bytes(input logic [1:0] code);
    return SPAN_W'(1) << code;
  endfunction

endpackage

// File: rtl/ldspec_slot.sv
module ldspec_slot
  import ldspec_pkg::*;
#(
  parameter int REG_W  = 7,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic [1:0]        snoop_size,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_clear,
  output logic              valid,
  output logic              alloc_match,
  output logic              chk_hit
);

  localparam int EXT_W = ADDR_W + 1;

  logic              valid_q;
  logic [REG_W-1:0]  reg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;

  logic [EXT_W-1:0] own_lo, own_hi, st_lo, st_hi;
  logic             overlap, snoop_kill, chk_match, clear_kill;

  always_comb begin
    own_lo = {1'b0, addr_q};
    own_hi = own_lo + EXT_W'(span_bytes(size_q));
    st_lo  = {1'b0, snoop_addr};
    st_hi  = st_lo + EXT_W'(span_bytes(snoop_size));
    overlap = (own_lo < st_hi) && (st_lo < own_hi);
  end

  assign snoop_kill  = snoop_valid && valid_q && overlap;
  assign chk_match   = valid_q && (reg_q == chk_reg);
  assign clear_kill  = chk_valid && chk_clear && chk_match;
  assign chk_hit     = chk_valid && chk_match && !snoop_kill && !flush;
  assign alloc_match = valid_q && (reg_q == alloc_reg);
  assign valid       = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
    end else if (flush || snoop_kill || clear_kill) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      reg_q  <= wr_reg;
      addr_q <= wr_addr;
      size_q <= wr_size;
    end
  end

endmodule

// File: rtl/ldspec_victim.sv
module ldspec_victim #(
  parameter int ENTRIES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_valid,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] wr_sel
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q, free_idx, match_idx, wr_idx;
  logic             free_found, match_found, use_rr;

  always_comb begin
    free_found  = 1'b0;
    free_idx    = '0;
    match_found = 1'b0;
    match_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
      if (match_vec[i]) begin
        match_found = 1'b1;
        match_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (match_found)     wr_idx = match_idx;
    else if (free_found) wr_idx = free_idx;
    else                 wr_idx = ptr_q;
  end

  assign use_rr = alloc_valid && !match_found && !free_found;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      wr_sel[i] = alloc_valid && (wr_idx == IDX_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (use_rr) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + IDX_W'(1);
    end
  end

endmodule

// File: rtl/ldspec_table.sv
module ldspec_table
  import ldspec_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              alloc_valid,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [1:0]        alloc_size,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic [1:0]        snoop_size,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_clear,
  output logic              chk_hit,
  output logic              chk_recover
);

  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] wr_sel;
  logic               any_hit;

  ldspec_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk         (clk),
    .rst         (rst),
    .alloc_valid (alloc_valid),
    .valid_vec   (valid_vec),
    .match_vec   (match_vec),
    .wr_sel      (wr_sel)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    ldspec_slot #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_slot (
      .clk         (clk),
      .rst         (rst),
      .flush       (flush),
      .wr_en       (wr_sel[g]),
      .wr_reg      (alloc_reg),
      .wr_addr     (alloc_addr),
      .wr_size     (alloc_size),
      .alloc_reg   (alloc_reg),
      .snoop_valid (snoop_valid),
      .snoop_addr  (snoop_addr),
      .snoop_size  (snoop_size),
      .chk_valid   (chk_valid),
      .chk_reg     (chk_reg),
      .chk_clear   (chk_clear),
      .valid       (valid_vec[g]),
      .alloc_match (match_vec[g]),
      .chk_hit     (hit_vec[g])
    );
  end

  assign any_hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_hit     <= 1'b0;
      chk_recover <= 1'b0;
    end else begin
      chk_hit     <= chk_valid && any_hit;
      chk_recover <= chk_valid && !any_hit;
    end
  end

endmodule

// File: rtl/ldspec_table_chk.sv
module ldspec_table_chk #(
  parameter int ENTRIES = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               flush,
  input logic               alloc_valid,
  input logic               chk_valid,
  input logic               chk_hit,
  input logic               chk_recover,
  input logic [ENTRIES-1:0] valid_vec
);

  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(chk_hit && chk_recover)); // R5

  AST_REQ_GETS_RESULT: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> (chk_hit || chk_recover)); // R5

  AST_NO_RESULT_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !(chk_hit || chk_recover)); // R5

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (flush && !alloc_valid) |=> (valid_vec == '0)); // R9

  AST_FLUSH_CHECK_FAILS: assert property (@(posedge clk) disable iff (rst)
    (flush && chk_valid) |=> chk_recover); // R9

  AST_GROWTH_NEEDS_ALLOC: assert property (@(posedge clk) disable iff (rst)
    !alloc_valid |=> ($countones(valid_vec) <= $countones($past(valid_vec)))); // R1

  AST_GROWTH_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    alloc_valid |=> ($countones(valid_vec) <= $countones($past(valid_vec)) + 1)); // R6

endmodule

bind ldspec_table ldspec_table_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .flush       (flush),
  .alloc_valid (alloc_valid),
  .chk_valid   (chk_valid),
  .chk_hit     (chk_hit),
  .chk_recover (chk_recover),
  .valid_vec   (valid_vec)
);

// File: tb/ldspec_table_test.sv
`timescale 1ns/1ps
module ldspec_table_test;

  localparam int N  = 8;
  localparam int RW = 7;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush = 1'b0;
  logic          alloc_valid = 1'b0;
  logic [RW-1:0] alloc_reg = '0;
  logic [AW-1:0] alloc_addr = '0;
  logic [1:0]    alloc_size = '0;
  logic          snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic [1:0]    snoop_size = '0;
  logic          chk_valid = 1'b0;
  logic [RW-1:0] chk_reg = '0;
  logic          chk_clear = 1'b0;
  logic          chk_hit, chk_recover;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ldspec_table #(.ENTRIES(N), .REG_W(RW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_reg(alloc_reg),
    .alloc_addr(alloc_addr), .alloc_size(alloc_size),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_size(snoop_size),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_clear(chk_clear),
    .chk_hit(chk_hit), .chk_recover(chk_recover)
  );

  // reference model
  bit            mv [N];
  logic [RW-1:0] mr [N];
  logic [AW-1:0] ma [N];
  logic [1:0]    ms [N];
  int            mptr = 0;

  function automatic bit overlaps(input logic [AW-1:0] a, input logic [1:0] sa,
                                  input logic [AW-1:0] b, input logic [1:0] sb);
    longint unsigned alo, ahi, blo, bhi;
    alo = longint'(a); ahi = alo + (64'd1 << sa);
    blo = longint'(b); bhi = blo + (64'd1 << sb);
    return (alo < bhi) && (blo < ahi);
  endfunction

  task automatic check(input string tag, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, got, exp);
    end
  endtask

  task automatic step(input bit fl,
                      input bit av, input int ar, input int aa, input int asz,
                      input bit sv, input int sa, input int ssz,
                      input bit cv, input int cr, input bit cc,
                      input string tag);
    bit pre [N];
    int ci, tgt;
    bit e_hit, killed;
    string t;
    flush = fl;
    alloc_valid = av; alloc_reg = RW'(ar); alloc_addr = AW'(aa); alloc_size = 2'(asz);
    snoop_valid = sv; snoop_addr = AW'(sa); snoop_size = 2'(ssz);
    chk_valid = cv; chk_reg = RW'(cr); chk_clear = cc;
    for (int i = 0; i < N; i++) pre[i] = mv[i];
    ci = -1;
    for (int i = 0; i < N; i++) if (mv[i] && mr[i] == RW'(cr)) ci = i;
    killed = (ci >= 0) && sv && overlaps(ma[ci], ms[ci], AW'(sa), 2'(ssz));
    e_hit = cv && (ci >= 0) && !fl && !killed;
    tgt = -1;
    if (av) begin
      for (int i = N - 1; i >= 0; i--) if (pre[i] && mr[i] == RW'(ar)) tgt = i;
      if (tgt < 0) for (int i = N - 1; i >= 0; i--) if (!pre[i]) tgt = i;
      if (tgt < 0) begin tgt = mptr; mptr = (mptr + 1) % N; end
    end
    for (int i = 0; i < N; i++) begin
      if (fl) mv[i] = 1'b0;
      if (sv && pre[i] && overlaps(ma[i], ms[i], AW'(sa), 2'(ssz))) mv[i] = 1'b0;
    end
    if (e_hit && cc) mv[ci] = 1'b0;
    if (av) begin
      mv[tgt] = 1'b1; mr[tgt] = RW'(ar); ma[tgt] = AW'(aa); ms[tgt] = 2'(asz);
    end
    if (tag != "") t = tag;
    else if (!cv) t = "R5";
    else if (fl) t = "R9";
    else if (killed) t = "R7";
    else if (e_hit) t = "R3";
    else t = "R4";
    @(posedge clk);
    #1;
    flush = 1'b0; alloc_valid = 1'b0; snoop_valid = 1'b0; chk_valid = 1'b0; chk_clear = 1'b0;
    @(negedge clk);
    check(t, chk_hit, e_hit, "chk_hit");
    check(t, chk_recover, cv && !e_hit, "chk_recover");
  endtask

  task automatic alloc(input int r, input int a, input int s, input string tag);
    step(0, 1, r, a, s, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic snoop(input int a, input int s, input string tag);
    step(0, 0, 0, 0, 0, 1, a, s, 0, 0, 0, tag);
  endtask
  task automatic chk(input int r, input bit c, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, r, c, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < N; i++) mv[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12", chk_hit, 1'b0, "chk_hit in reset");
    check("R12", chk_recover, 1'b0, "chk_recover in reset");
    rst = 1'b0;
    chk(5, 0, "R12");               // empty after reset
    chk(5, 0, "R4");
    alloc(5, 'h100, 2, "R5");
    chk(5, 0, "R1");
    snoop('h104, 2, "R5");
    chk(5, 0, "R3");                // abuts above
    snoop('hF8, 3, "R5");
    chk(5, 0, "R3");                // abuts below
    snoop('hFC, 3, "R5");
    chk(5, 0, "R2");                // wide store covers entry
    alloc(5, 'h100, 2, "R1");
    snoop('h103, 0, "R5");
    chk(5, 0, "R2");                // single byte overlap
    alloc(9, 'h200, 3, "R5");
    alloc(9, 'h300, 3, "R5");
    snoop('h200, 3, "R5");
    chk(9, 0, "R6");                // old range gone
    snoop('h300, 3, "R5");
    chk(9, 0, "R6");
    alloc(3, 'h40, 1, "R5");
    step(0, 0, 0, 0, 0, 1, 'h41, 0, 1, 3, 0, "R7");
    alloc(4, 'h80, 2, "R5");
    chk(4, 0, "R8");
    chk(4, 1, "R8");
    chk(4, 0, "R8");
    step(1, 1, 6, 'h600, 2, 0, 0, 0, 0, 0, 0, "R11");
    chk(6, 0, "R11");
    step(0, 1, 7, 'h500, 2, 1, 'h500, 2, 0, 0, 0, "R11");
    chk(7, 0, "R11");
    alloc(1, 'h10, 0, "R5");
    alloc(2, 'h20, 0, "R5");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    chk(1, 0, "R9");
    chk(2, 0, "R9");
    alloc(1, 'h10, 0, "R5");
    step(1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, "R9");
    // replacement order
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    for (int i = 0; i < N; i++) alloc(10 + i, 'h1000 + 16 * i, 2, "R10");
    alloc(18, 'h2000, 2, "R10");
    chk(10, 0, "R10");
    chk(11, 0, "R10");
    alloc(19, 'h2010, 2, "R10");
    chk(11, 0, "R10");
    chk(12, 0, "R10");
    chk(14, 1, "R10");
    alloc(20, 'h2020, 2, "R10");    // lowest free entry
    alloc(21, 'h2030, 2, "R10");    // pointer replacement
    chk(12, 0, "R10");
    chk(13, 0, "R10");
    chk(20, 0, "R10");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 64) == 0,
           $urandom % 2, $urandom % 16, $urandom % 64, $urandom % 4,
           ($urandom % 3) == 0, $urandom % 64, $urandom % 4,
           $urandom % 2, $urandom % 16, ($urandom % 4) == 0, "");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule